// File: doc/BRIEF.md
# Store Queue with In-Place Post-Commit Drain

This block is a circular queue of store entries. The same storage serves both as the speculative store queue and as the write buffer that holds stores after commit. Three pointers split the ring. The drain head marks the oldest entry. The commit pointer marks the boundary between committed stores and uncommitted ones. The allocation tail marks the next free slot. Committed ("senior") stores lie between the head and the commit pointer and wait for their cache write. Speculative stores lie between the commit pointer and the tail.

The core allocates one store per cycle and receives a slot tag. It later fills that slot with an address and data. It can retire any number of stores per cycle up to the width of the commit count. Commit only moves the commit pointer and never waits for a cache write. Senior stores are presented one at a time, oldest first, on a cache-write port. Each acknowledge frees one entry. A mispredict flush rewinds the tail to a given tag but never reaches below the commit pointer. Loads look up the queue with an age tag, which is the tail value seen when the load was dispatched. They receive data from the youngest older matching store, whether that store is speculative or senior.

Pointer tags are one bit wider than the slot index. The top bit is a wrap bit, so a full ring and an empty ring can be told apart. DEPTH must be a power of two and at least 2.

Top module: `store_senior_queue`

## Requirements
- R1: After reset the ring is empty. alloc_ready is 1, alloc_idx is 0, wr_valid is 0 and fwd_hit is 0.
- R2: alloc_idx gives the tail tag. The low IW bits are the slot and the top bit is the wrap bit. Each accepted allocation adds one to the tail tag. alloc_ready is 0 while DEPTH entries are occupied, counting senior and speculative entries together. While it is 0, alloc_valid leaves the tail unchanged, until an acknowledged drain frees a slot.
- R3: commit_cnt moves the commit pointer forward by the count, but never past the tail. Commit does not wait for any cache write.
- R4: wr_valid is 1 whenever senior entries exist. wr_addr and wr_data show the oldest senior entry. Each cycle with wr_valid and wr_ack both high moves the head forward by exactly one, so entries drain in program order. The head does not move in any other cycle.
- R5: A load presented on load_valid gets its registered result one cycle later. fwd_hit is 1 when an entry at a tag from the head up to, but not including, the smaller of load_age and the tail has been filled and its address equals load_addr exactly. fwd_data is then the data of the youngest such entry. Otherwise fwd_hit is 0.
- R6: Senior entries keep forwarding until they are acknowledged. After the acknowledge, they no longer forward.
- R7: flush_valid sets the tail to flush_tail when flush_tail lies between the commit pointer and the current tail. Otherwise the tail is set to the commit pointer. Senior entries are unaffected. An allocation in the same cycle as a flush is ignored.
- R8: When commit and flush happen in the same cycle, the commit is applied first. The flush bound then uses the new commit pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to allocate one store slot |
| alloc_ready | output | 1 | A slot is free at the tail |
| alloc_idx | output | PW | Tail tag handed to the allocating store |
| fill_valid | input | 1 | Write address and data into a slot |
| fill_slot | input | IW | Slot index to fill |
| fill_addr | input | AW | Store address |
| fill_data | input | DW | Store data |
| commit_cnt | input | CW | Number of stores committing this cycle |
| flush_valid | input | 1 | Mispredict rewind of the tail |
| flush_tail | input | PW | Tail tag to rewind to |
| load_valid | input | 1 | Forwarding lookup request |
| load_addr | input | AW | Load address |
| load_age | input | PW | Tail tag seen by the load at dispatch |
| fwd_hit | output | 1 | Registered: an older matching store was found |
| fwd_data | output | DW | Registered: data of the youngest older match |
| wr_valid | output | 1 | A senior entry is waiting for its cache write |
| wr_addr | output | AW | Address of the oldest senior entry |
| wr_data | output | DW | Data of the oldest senior entry |
| wr_ack | input | 1 | Cache has accepted the presented write |

## Verification
The bench aims at the points where the three regions meet.

- **Forwarding age bound.** Loads use age tags placed just before and just after a same-address store. A search that ignored the age would return a younger store. One that picked the oldest match would return stale data.
- **Commit clamp.** A commit count larger than the speculative region is followed by a full drain. A design that overshot the tail would keep wr_valid high with nothing to write.
- **Full ring.** The ring is filled entirely with senior stores. A design that let allocation overwrite a senior slot would move alloc_idx past a store that is still waiting for the cache.
- **Flush boundaries.** Flushes are aimed at tags older than the commit pointer, including one in the same cycle as a commit. A design without the clamp would discard committed stores or resurrect freed ones, and later forwarding would show it.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int SQ_DEPTH = 8;
  localparam int SQ_AW    = 32;
  localparam int SQ_DW    = 32;
  localparam int SQ_CW    = 3;
endpackage

// File: rtl/sq_ptr_ctrl.sv
module sq_ptr_ctrl #(
  parameter int DEPTH = 8,
  parameter int CW    = 3,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_valid,
  input  logic [CW-1:0] commit_cnt,
  input  logic          flush_valid,
  input  logic [PW-1:0] flush_tail,
  input  logic          wr_ack,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic          alloc_ready,
  output logic          alloc_fire,
  output logic          wr_valid
);
  logic [PW-1:0] head_q, cmt_q, tail_q;
  logic [PW-1:0] head_nx, cmt_nx, tail_nx;
  logic [PW-1:0] spec_cnt, used_cnt, cstep, fdist, rem;
  logic          wr_fire;

  assign head        = head_q;
  assign tail        = tail_q;
  assign used_cnt    = tail_q - head_q;
  assign spec_cnt    = tail_q - cmt_q;
  assign alloc_ready = (used_cnt < PW'(DEPTH));
  assign alloc_fire  = alloc_valid && alloc_ready && !flush_valid;
  assign wr_valid    = (cmt_q != head_q);
  assign wr_fire     = wr_valid && wr_ack;

  always_comb begin
    if (32'(commit_cnt) > 32'(spec_cnt)) cstep = spec_cnt;
    else                                 cstep = PW'(commit_cnt);
    cmt_nx  = cmt_q + cstep;
    head_nx = head_q + {{(PW-1){1'b0}}, wr_fire};
    fdist   = flush_tail - cmt_nx;
    rem     = tail_q - cmt_nx;
    tail_nx = tail_q;
    if (flush_valid)     tail_nx = (fdist > rem) ? cmt_nx : flush_tail;
    else if (alloc_fire) tail_nx = tail_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      cmt_q  <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_nx;
      cmt_q  <= cmt_nx;
      tail_q <= tail_nx;
    end
  end

  // R2: occupancy never exceeds the ring
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    (tail_q - head_q) <= PW'(DEPTH));
  // R2: a refused allocation leaves the tail alone
  assert_alloc_stall_R2: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && !alloc_ready && !flush_valid) |=> $stable(tail_q));
  // R3: commit pointer stays inside [head, tail]
  assert_commit_inside_R3: assert property (@(posedge clk) disable iff (rst)
    (cmt_q - head_q) <= (tail_q - head_q));
  // R4: head moves one step per acknowledged write
  assert_drain_step_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ack) |=> (head_q == $past(head_q) + 1'b1));
  // R4: head holds without an acknowledged write
  assert_head_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && wr_ack) |=> $stable(head_q));
  // R7: a flush never shrinks the senior region
  assert_senior_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (flush_valid && !wr_ack) |=> ((cmt_q - head_q) >= $past(cmt_q - head_q)));
endmodule

// File: rtl/sq_entry_file.sv
module sq_entry_file #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_fire,
  input  logic [IW-1:0] alloc_slot,
  input  logic          fill_valid,
  input  logic [IW-1:0] fill_slot,
  input  logic [AW-1:0] fill_addr,
  input  logic [DW-1:0] fill_data,
  output logic [AW-1:0] addr_o [DEPTH],
  output logic [DW-1:0] data_o [DEPTH],
  output logic [DEPTH-1:0] filled_o
);
  always_ff @(posedge clk) begin
    if (fill_valid) begin
      addr_o[fill_slot] <= fill_addr;
      data_o[fill_slot] <= fill_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) filled_o <= '0;
    else begin
      if (alloc_fire) filled_o[alloc_slot] <= 1'b0;
      if (fill_valid) filled_o[fill_slot]  <= 1'b1;
    end
  end

  // R5: a fill lands in the addressed slot
  assert_fill_marks_R5: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> filled_o[$past(fill_slot)]);
endmodule

// File: rtl/sq_fwd_match.sv
module sq_fwd_match #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH) + 1,
  localparam int IW   = PW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_valid,
  input  logic [AW-1:0] load_addr,
  input  logic [PW-1:0] load_age,
  input  logic [PW-1:0] head,
  input  logic [PW-1:0] tail,
  input  logic [AW-1:0] addr_i [DEPTH],
  input  logic [DW-1:0] data_i [DEPTH],
  input  logic [DEPTH-1:0] filled_i,
  output logic          fwd_hit,
  output logic [DW-1:0] fwd_data
);
  logic [PW-1:0] lim, cnt, pos;
  logic [IW-1:0] slot;
  logic          hit;
  logic [DW-1:0] hdata;

  always_comb begin
    lim   = load_age - head;
    cnt   = tail - head;
    if (lim > cnt) lim = cnt;
    hit   = 1'b0;
    hdata = '0;
    pos   = head;
    slot  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      pos  = head + PW'(k);
      slot = pos[IW-1:0];
      if ((PW'(k) < lim) && filled_i[slot] && (addr_i[slot] == load_addr)) begin
        hit   = 1'b1;
        hdata = data_i[slot];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_hit  <= 1'b0;
      fwd_data <= '0;
    end else begin
      fwd_hit  <= load_valid && hit;
      fwd_data <= hdata;
    end
  end

  // R5: no hit is reported without a lookup the cycle before
  assert_hit_needs_load_R5: assert property (@(posedge clk) disable iff (rst)
    fwd_hit |-> $past(load_valid));
endmodule

// File: rtl/store_senior_queue.sv
module store_senior_queue #(
  parameter int DEPTH = sq_pkg::SQ_DEPTH,
  parameter int AW    = sq_pkg::SQ_AW,
  parameter int DW    = sq_pkg::SQ_DW,
  parameter int CW    = sq_pkg::SQ_CW,
  localparam int PW   = $clog2(DEPTH) + 1,
  localparam int IW   = PW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  output logic [PW-1:0] alloc_idx,
  input  logic          fill_valid,
  input  logic [IW-1:0] fill_slot,
  input  logic [AW-1:0] fill_addr,
  input  logic [DW-1:0] fill_data,
  input  logic [CW-1:0] commit_cnt,
  input  logic          flush_valid,
  input  logic [PW-1:0] flush_tail,
  input  logic          load_valid,
  input  logic [AW-1:0] load_addr,
  input  logic [PW-1:0] load_age,
  output logic          fwd_hit,
  output logic [DW-1:0] fwd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack
);
  logic [PW-1:0]    head, tail;
  logic             alloc_fire;
  logic [AW-1:0]    ent_addr [DEPTH];
  logic [DW-1:0]    ent_data [DEPTH];
  logic [DEPTH-1:0] ent_filled;

  sq_ptr_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ptr (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .commit_cnt(commit_cnt),
    .flush_valid(flush_valid), .flush_tail(flush_tail), .wr_ack(wr_ack),
    .head(head), .tail(tail), .alloc_ready(alloc_ready),
    .alloc_fire(alloc_fire), .wr_valid(wr_valid)
  );

  sq_entry_file #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ent (
    .clk(clk), .rst(rst), .alloc_fire(alloc_fire), .alloc_slot(tail[IW-1:0]),
    .fill_valid(fill_valid), .fill_slot(fill_slot), .fill_addr(fill_addr),
    .fill_data(fill_data), .addr_o(ent_addr), .data_o(ent_data),
    .filled_o(ent_filled)
  );

  sq_fwd_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
    .clk(clk), .rst(rst), .load_valid(load_valid), .load_addr(load_addr),
    .load_age(load_age), .head(head), .tail(tail), .addr_i(ent_addr),
    .data_i(ent_data), .filled_i(ent_filled), .fwd_hit(fwd_hit),
    .fwd_data(fwd_data)
  );

  assign alloc_idx = tail;
  assign wr_addr   = ent_addr[head[IW-1:0]];
  assign wr_data   = ent_data[head[IW-1:0]];
endmodule

// File: tb/store_senior_queue_bench.sv
`timescale 1ns/1ps
module store_senior_queue_bench;
  localparam int DEPTH = 8, AW = 32, DW = 32, CW = 3;
  localparam int PW = $clog2(DEPTH) + 1, IW = PW - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_valid = 0, fill_valid = 0, flush_valid = 0, load_valid = 0, wr_ack = 0;
  logic [IW-1:0] fill_slot = '0;
  logic [AW-1:0] fill_addr = '0, load_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic [CW-1:0] commit_cnt = '0;
  logic [PW-1:0] flush_tail = '0, load_age = '0;
  logic alloc_ready, fwd_hit, wr_valid;
  logic [PW-1:0] alloc_idx;
  logic [DW-1:0] fwd_data, wr_data;
  logic [AW-1:0] wr_addr;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  store_senior_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CW(CW)) u_store_senior_queue (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_idx(alloc_idx), .fill_valid(fill_valid), .fill_slot(fill_slot),
    .fill_addr(fill_addr), .fill_data(fill_data), .commit_cnt(commit_cnt),
    .flush_valid(flush_valid), .flush_tail(flush_tail), .load_valid(load_valid),
    .load_addr(load_addr), .load_age(load_age), .fwd_hit(fwd_hit),
    .fwd_data(fwd_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_store(input logic [AW-1:0] a, input logic [DW-1:0] d, output logic [PW-1:0] idx);
    idx = alloc_idx;
    alloc_valid = 1; step(); alloc_valid = 0;
    fill_valid = 1; fill_slot = idx[IW-1:0]; fill_addr = a; fill_data = d;
    step(); fill_valid = 0;
  endtask

  task automatic commit(input int n);
    commit_cnt = CW'(n); step(); commit_cnt = '0;
  endtask

  task automatic ack();
    wr_ack = 1; step(); wr_ack = 0;
  endtask

  task automatic look(input logic [AW-1:0] a, input logic [PW-1:0] age,
                      input string req, input logic eh, input logic [DW-1:0] ed);
    load_valid = 1; load_addr = a; load_age = age; step(); load_valid = 0;
    chk({req, " hit"}, fwd_hit, eh);
    if (eh) chk({req, " data"}, fwd_data, ed);
  endtask

  task automatic t_reset();
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 alloc_idx", alloc_idx, 0);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 fwd_hit", fwd_hit, 0);
  endtask

  task automatic t_forward();
    logic [PW-1:0] i;
    put_store(32'h100, 32'hD1, i); chk("R2 idx0", i, 0);
    put_store(32'h200, 32'hD2, i); chk("R2 idx1", i, 1);
    put_store(32'h100, 32'hD3, i); chk("R2 idx2", i, 2);
    chk("R2 tail", alloc_idx, 3);
    look(32'h100, 3, "R5 youngest", 1, 32'hD3);
    look(32'h100, 2, "R5 age bound", 1, 32'hD1);
    look(32'h100, 0, "R5 none older", 0, 0);
    look(32'h300, 3, "R5 no match", 0, 0);
  endtask

  task automatic t_commit();
    commit(2);
    chk("R3 wr_valid", wr_valid, 1);
    chk("R4 wr_addr", wr_addr, 32'h100);
    chk("R4 wr_data", wr_data, 32'hD1);
    commit(5);
    look(32'h100, 3, "R6 senior fwd", 1, 32'hD3);
    ack();
    chk("R4 second addr", wr_addr, 32'h200);
    chk("R4 second data", wr_data, 32'hD2);
    look(32'h100, 3, "R6 still fwd", 1, 32'hD3);
    ack(); ack();
    chk("R3 clamp drained", wr_valid, 0);
    look(32'h100, 3, "R6 released", 0, 0);
  endtask

  task automatic t_full();
    logic [PW-1:0] i;
    for (int k = 0; k < DEPTH; k++) put_store(AW'(32'h40 + k), DW'(32'hA0 + k), i);
    commit(4); commit(4);
    chk("R2 full", alloc_ready, 0);
    alloc_valid = 1; step(); alloc_valid = 0;
    chk("R2 stall idx", alloc_idx, 11);
    ack();
    chk("R2 freed", alloc_ready, 1);
    look(32'h41, 11, "R6 wrapped senior", 1, 32'hA1);
  endtask

  task automatic t_flush();
    logic [PW-1:0] i;
    put_store(32'h41, 32'hEE, i); chk("R2 wrap idx", i, 11);
    look(32'h41, 12, "R5 spec youngest", 1, 32'hEE);
    flush_valid = 1; flush_tail = 11; step(); flush_valid = 0;
    chk("R7 tail", alloc_idx, 11);
    look(32'h41, 12, "R7 flushed gone", 1, 32'hA1);
    flush_valid = 1; flush_tail = 5; step(); flush_valid = 0;
    chk("R7 clamp", alloc_idx, 11);
    look(32'h44, 11, "R7 senior kept", 1, 32'hA4);
    flush_valid = 1; flush_tail = 11; alloc_valid = 1; step();
    flush_valid = 0; alloc_valid = 0;
    chk("R7 alloc ignored", alloc_idx, 11);
  endtask

  task automatic t_commit_flush();
    logic [PW-1:0] i;
    ack(); ack();
    put_store(32'h77, 32'hF1, i);
    put_store(32'h88, 32'hF2, i); chk("R8 setup", i, 12);
    commit_cnt = 1; flush_valid = 1; flush_tail = 11; step();
    commit_cnt = 0; flush_valid = 0;
    chk("R8 tail", alloc_idx, 12);
    look(32'h77, 12, "R8 committed kept", 1, 32'hF1);
    look(32'h88, 13, "R8 younger dropped", 0, 0);
  endtask

  initial begin
    step(); step(); rst = 0; step();
    t_reset();
    t_forward();
    t_commit();
    t_full();
    t_flush();
    t_commit_flush();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule